// File: doc/BRIEF.md
# Two-Domain Clock Stop Controller

This block lets software halt and resume the two clocks of a bridge: the host bus clock and the external interconnect clock. Software writes stop bits through a small register port on the bus clock. Each domain has its own gate unit. A gate unit carries the stop request through a synchronizer clocked by that domain's free-running source clock. A two-state machine then drops or raises the domain's clock enable, which stands in for a glitch-free clock gate. Clearing a stop bit brings the clock back through the same path, so restart takes as long as stop.

Which clocks a stop bit reaches depends on the clocking-mode strap. The strap is captured only while reset is held. In interconnect-master mode each stop bit gates only its own domain. In bus-master mode the bus stop bit gates both domains, and the interconnect stop bit cannot be set. The block also holds one register shared with the interconnect side. That register may only be accessed while the interconnect clock runs. An access made while the interconnect clock is stopped, or while a stop of it is requested, is refused and raises a sticky error bit.

Each gate unit has two states. GS_RUN holds the enable high. GS_HALT holds it low. The transition GS_RUN to GS_HALT fires when the synchronized stop request is high. The transition GS_HALT to GS_RUN fires when the synchronized request is low.

Top module: `clk_stop_ctrl`

## Requirements
- R1: After reset both enables are 1, the control register (address 0) reads 0, the status register (address 1) reads 3 (bit0 = interconnect clock running, bit1 = bus clock running, bit2 = access error), and the shared register (address 2) reads 0. Address 3 reads 0.
- R2: The strap (1 = interconnect-master mode, 0 = bus-master mode) is captured only while reset is low. Changing it after reset has no effect on the mode.
- R3: In interconnect-master mode, writing 1 to control bit0 stops the interconnect enable and leaves the bus enable at 1. Writing 0 to control bit0 restarts the interconnect enable.
- R4: Writing 1 to control bit1 stops the bus enable. In interconnect-master mode the interconnect enable is not affected. In bus-master mode both enables stop.
- R5: In bus-master mode, writes to control bit0 are ignored. The bit reads 0 and the interconnect enable stays 1.
- R6: After the write edge, an enable changes on the SYNC_STAGES+1-th rising edge of its own domain clock, which is never fewer than 2 edges. Restart follows the same timing as stop.
- R7: Status bit1 mirrors the bus enable. Status bit0 follows the interconnect enable through a SYNC_STAGES-flop synchronizer on the bus clock, so it changes only after the enable has changed.
- R8: While the interconnect clock runs and no stop of it is requested, the shared register is written and read back normally.
- R9: A shared-register access made while the interconnect clock is stopped, or while a stop of it is requested, is refused. A refused read returns 0, a refused write is discarded, and either sets status bit2.
- R10: Status bit2 stays set until software writes 1 to status bit2. Writing 0 to that bit leaves the error set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk_i | input | 1 | Free-running bus clock source |
| xclk_i | input | 1 | Free-running interconnect clock source |
| rst_n_i | input | 1 | Active-low asynchronous reset |
| strap_xmaster_i | input | 1 | Clocking-mode strap (1 = interconnect master) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, valid while reg_rd_i is high |
| hclk_en_o | output | 1 | Bus clock gate enable |
| xclk_en_o | output | 1 | Interconnect clock gate enable |

## Verification
The bench builds the block with DATA_W = 16 and SYNC_STAGES = 2, and runs the two clocks at 10 ns and 14 ns periods. The clocks have a fractional phase offset, so their edges never coincide. This lets the bench count the domain edges between a write and an enable change exactly, and expect the third edge in each domain. The bench runs both strap values through separate resets. That covers the single-domain and the both-domain stop paths, the ignored interconnect stop bit, and refused shared-register accesses.

// File: rtl/csc_pkg.sv
`timescale 1ns/1ps
package csc_pkg;
    typedef enum logic {
        GS_RUN  = 1'b0,
        GS_HALT = 1'b1
    } gate_state_t;

    localparam int ADR_CTRL   = 0;
    localparam int ADR_STAT   = 1;
    localparam int ADR_SHARED = 2;

    localparam int CTRL_XSTOP_BIT = 0;
    localparam int CTRL_BSTOP_BIT = 1;
    localparam int STAT_XRUN_BIT  = 0;
    localparam int STAT_BRUN_BIT  = 1;
    localparam int STAT_ERR_BIT   = 2;
endpackage

// File: rtl/csc_sync.sv
`timescale 1ns/1ps
module csc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/csc_gate.sv
`timescale 1ns/1ps
module csc_gate
    import csc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic stop_req_i,
    output logic clk_en_o
);
    logic        req_s;
    gate_state_t state_q, state_d;

    csc_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_req_sync (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .d_i     (stop_req_i),
        .q_o     (req_s)
    );

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            state_q <= GS_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_RUN:  if (req_s)  state_d = GS_HALT;
            GS_HALT: if (!req_s) state_d = GS_RUN;
        endcase
    end

    always_comb begin
        clk_en_o = 1'b1;
        unique case (state_q)
            GS_RUN:  clk_en_o = 1'b1;
            GS_HALT: clk_en_o = 1'b0;
        endcase
    end

    // R6: a stop or restart needs the request held at least two domain edges back
    p_stop_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $fell(clk_en_o) |-> $past(stop_req_i, 2));
    p_restart_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(clk_en_o) |-> !$past(stop_req_i, 2));
endmodule

// File: rtl/clk_stop_ctrl.sv
`timescale 1ns/1ps
module clk_stop_ctrl
    import csc_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              hclk_i,
    input  logic              xclk_i,
    input  logic              rst_n_i,
    input  logic              strap_xmaster_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              hclk_en_o,
    output logic              xclk_en_o
);
    localparam int N_DOM  = 2;
    localparam int DOM_BUS = 0;
    localparam int DOM_XC  = 1;

    logic              mode_q;
    logic              ctl_xstop_q, ctl_bstop_q, acc_err_q;
    logic [DATA_W-1:0] shared_q;
    logic              x_run_s, blocked, acc_hit;
    logic              sel_ctrl, sel_stat, sel_shared;
    logic [N_DOM-1:0]  dom_clk, dom_req, dom_en;

    // Strap captured only while reset is held
    always_ff @(posedge hclk_i) begin
        if (!rst_n_i) mode_q <= strap_xmaster_i;
    end

    assign sel_ctrl   = (reg_addr_i == ADDR_W'(ADR_CTRL));
    assign sel_stat   = (reg_addr_i == ADDR_W'(ADR_STAT));
    assign sel_shared = (reg_addr_i == ADDR_W'(ADR_SHARED));

    assign dom_clk[DOM_BUS] = hclk_i;
    assign dom_clk[DOM_XC]  = xclk_i;
    assign dom_req[DOM_BUS] = ctl_bstop_q;
    assign dom_req[DOM_XC]  = ctl_xstop_q | (~mode_q & ctl_bstop_q);

    for (genvar g = 0; g < N_DOM; g++) begin : g_dom
        csc_gate #(.STAGES(SYNC_STAGES)) u_gate (
            .clk_i      (dom_clk[g]),
            .rst_n_i    (rst_n_i),
            .stop_req_i (dom_req[g]),
            .clk_en_o   (dom_en[g])
        );
    end

    csc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_xrun_sync (
        .clk_i   (hclk_i),
        .rst_n_i (rst_n_i),
        .d_i     (dom_en[DOM_XC]),
        .q_o     (x_run_s)
    );

    assign hclk_en_o = dom_en[DOM_BUS];
    assign xclk_en_o = dom_en[DOM_XC];

    assign blocked = dom_req[DOM_XC] | ~x_run_s;
    assign acc_hit = (reg_wr_i | reg_rd_i) & sel_shared & blocked;

    always_ff @(posedge hclk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            ctl_xstop_q <= 1'b0;
            ctl_bstop_q <= 1'b0;
            acc_err_q   <= 1'b0;
            shared_q    <= '0;
        end else begin
            if (reg_wr_i && sel_ctrl) begin
                ctl_bstop_q <= reg_wdata_i[CTRL_BSTOP_BIT];
                if (mode_q) ctl_xstop_q <= reg_wdata_i[CTRL_XSTOP_BIT];
            end
            if (reg_wr_i && sel_shared && !blocked) shared_q <= reg_wdata_i;
            if (acc_hit) begin
                acc_err_q <= 1'b1;
            end else if (reg_wr_i && sel_stat && reg_wdata_i[STAT_ERR_BIT]) begin
                acc_err_q <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_rd_i) begin
            case (reg_addr_i)
                ADDR_W'(ADR_CTRL): begin
                    reg_rdata_o[CTRL_XSTOP_BIT] = ctl_xstop_q;
                    reg_rdata_o[CTRL_BSTOP_BIT] = ctl_bstop_q;
                end
                ADDR_W'(ADR_STAT): begin
                    reg_rdata_o[STAT_XRUN_BIT] = x_run_s;
                    reg_rdata_o[STAT_BRUN_BIT] = dom_en[DOM_BUS];
                    reg_rdata_o[STAT_ERR_BIT]  = acc_err_q;
                end
                ADDR_W'(ADR_SHARED): begin
                    if (!blocked) reg_rdata_o = shared_q;
                end
                default: reg_rdata_o = '0;
            endcase
        end
    end

    // R2: mode holds once reset is released
    p_mode_held_r2: assert property (@(posedge hclk_i) disable iff (!rst_n_i)
        rst_n_i |=> $stable(mode_q));
    // R5: interconnect stop bit never set in bus-master mode
    p_xstop_ignored_r5: assert property (@(posedge hclk_i) disable iff (!rst_n_i)
        !mode_q |-> !ctl_xstop_q);
    // R9: refused read returns zero, refused write leaves shared data
    p_blocked_read_zero_r9: assert property (@(posedge hclk_i) disable iff (!rst_n_i)
        (reg_rd_i && sel_shared && !x_run_s) |-> (reg_rdata_o == '0));
    p_blocked_write_kept_r9: assert property (@(posedge hclk_i) disable iff (!rst_n_i)
        (reg_wr_i && sel_shared && !x_run_s) |=> $stable(shared_q));
    // R10: error stays set unless cleared by a write of 1
    p_err_sticky_r10: assert property (@(posedge hclk_i) disable iff (!rst_n_i)
        (acc_err_q && !(reg_wr_i && sel_stat && reg_wdata_i[STAT_ERR_BIT])) |=> acc_err_q);
endmodule

// File: tb/clk_stop_ctrl_test.sv
`timescale 1ns/1ps
module clk_stop_ctrl_test;
    localparam real HCLK_P = 10.0;
    localparam real XCLK_P = 14.0;
    localparam int  DW     = 16;
    localparam int  AW     = 2;
    localparam int  SYNC   = 2;
    localparam int  EXP_EDGES = SYNC + 1;

    logic          hclk = 1'b0, xclk = 1'b0, rst_n = 1'b0, strap = 1'b1;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          hclk_en, xclk_en;

    int checks = 0, failures = 0;
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    always #(HCLK_P/2) hclk = ~hclk;
    initial begin
        #2.5;
        forever #(XCLK_P/2) xclk = ~xclk;
    end

    clk_stop_ctrl #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(SYNC)) uut (
        .hclk_i(hclk), .xclk_i(xclk), .rst_n_i(rst_n), .strap_xmaster_i(strap),
        .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .hclk_en_o(hclk_en), .xclk_en_o(xclk_en)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected read data as the design returns it
    always @(negedge hclk) begin
        if (reg_rd) begin
            if (exp_q.size() == 0) begin
                check("scoreboard underrun", 16'd1, 16'd0);
            end else begin
                check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic rd(input int addr, input logic [DW-1:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge hclk); #0.1;
        reg_rd = 1'b1; reg_addr = AW'(addr);
        @(posedge hclk); #0.1;
        reg_rd = 1'b0;
    endtask

    task automatic wr(input int addr, input logic [DW-1:0] data);
        @(posedge hclk); #0.1;
        reg_wr = 1'b1; reg_addr = AW'(addr); reg_wdata = data;
        @(posedge hclk); #0.1;
        reg_wr = 1'b0;
    endtask

    task automatic edges_h(output int n);
        logic start;
        start = hclk_en; n = 0;
        while (n < 12) begin
            @(posedge hclk); #0.1; n++;
            if (hclk_en != start) break;
        end
    endtask

    task automatic edges_x(output int n);
        logic start;
        start = xclk_en; n = 0;
        while (n < 12) begin
            @(posedge xclk); #0.1; n++;
            if (xclk_en != start) break;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge hclk);
        #0.1;
    endtask

    task automatic do_reset(input logic s);
        rst_n = 1'b0; strap = s;
        idle(5);
        rst_n = 1'b1;
        idle(2);
    endtask

    initial begin
        repeat (150000) @(posedge hclk);
        check("watchdog expired", 16'd1, 16'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int nh, nx;
        // ---------- interconnect-master mode ----------
        do_reset(1'b1);
        check("R1 bus enable after reset", DW'(hclk_en), 16'd1);
        check("R1 interconnect enable after reset", DW'(xclk_en), 16'd1);
        rd(0, 16'h0000, "R1 control reset value");
        rd(1, 16'h0003, "R1 status reset value");
        rd(2, 16'h0000, "R1 shared reset value");
        rd(3, 16'h0000, "R1 unused address");

        wr(2, 16'hA5A5);
        rd(2, 16'hA5A5, "R8 shared write/read");

        wr(0, 16'h0001);
        edges_x(nx);
        check("R6 interconnect stop edges", DW'(nx), DW'(EXP_EDGES));
        check("R3 interconnect stopped", DW'(xclk_en), 16'd0);
        check("R3 bus still running", DW'(hclk_en), 16'd1);
        idle(10);
        rd(1, 16'h0002, "R7 status after interconnect stop");

        rd(2, 16'h0000, "R9 refused read");
        wr(2, 16'h1234);
        rd(1, 16'h0006, "R9 error set");
        wr(1, 16'h0000);
        rd(1, 16'h0006, "R10 write of 0 keeps error");
        wr(1, 16'h0004);
        rd(1, 16'h0002, "R10 error cleared by write of 1");

        wr(0, 16'h0000);
        edges_x(nx);
        check("R6 interconnect restart edges", DW'(nx), DW'(EXP_EDGES));
        check("R3 interconnect restarted", DW'(xclk_en), 16'd1);
        idle(10);
        rd(1, 16'h0003, "R7 status after restart");
        rd(2, 16'hA5A5, "R9 refused write discarded");

        wr(0, 16'h0002);
        edges_h(nh);
        check("R6 bus stop edges", DW'(nh), DW'(EXP_EDGES));
        check("R4 bus stopped", DW'(hclk_en), 16'd0);
        idle(10);
        check("R4 interconnect unaffected in interconnect-master mode", DW'(xclk_en), 16'd1);
        rd(1, 16'h0001, "R7 status bus stopped");
        wr(0, 16'h0000);
        edges_h(nh);
        check("R6 bus restart edges", DW'(nh), DW'(EXP_EDGES));

        // ---------- bus-master mode ----------
        do_reset(1'b0);
        strap = 1'b1;
        rd(1, 16'h0003, "R1 status after second reset");
        wr(0, 16'h0001);
        rd(0, 16'h0000, "R5 interconnect stop bit ignored");
        idle(10);
        check("R5 interconnect enable unaffected", DW'(xclk_en), 16'd1);
        check("R2 strap change after reset has no effect", DW'(xclk_en), 16'd1);

        wr(0, 16'h0002);
        fork
            edges_h(nh);
            edges_x(nx);
        join
        check("R6 bus stop edges bus-master", DW'(nh), DW'(EXP_EDGES));
        check("R6 interconnect stop edges bus-master", DW'(nx), DW'(EXP_EDGES));
        check("R4 both stopped (bus)", DW'(hclk_en), 16'd0);
        check("R4 both stopped (interconnect)", DW'(xclk_en), 16'd0);
        idle(10);
        rd(1, 16'h0000, "R7 status both stopped");
        rd(2, 16'h0000, "R9 refused read bus-master");
        rd(1, 16'h0004, "R9 error after refused read");

        wr(0, 16'h0000);
        fork
            edges_h(nh);
            edges_x(nx);
        join
        check("R6 bus restart bus-master", DW'(nh), DW'(EXP_EDGES));
        check("R6 interconnect restart bus-master", DW'(nx), DW'(EXP_EDGES));
        idle(10);
        rd(1, 16'h0007, "R7 status running, error still set");

        idle(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule